// File: doc/BRIEF.md
# Sixteen-Operation Data-Processing ALU with Status Flags

This block is the arithmetic and logic stage of a 32-bit integer datapath. A 4-bit operation code picks one of sixteen functions of two operands: eight bitwise functions and eight adder-based functions. Four of the codes are compare and test forms. They compute a value and update the flags, but they never ask for a register write. The operand shifter sits upstream. It supplies its carry-out and a marker that says the shift was a left shift by zero.

The datapath is purely combinational. Next to it sits a registered status word holding negative, zero, carry and overflow (N, Z, C, V). The flags change on the clock edge only when the instruction asks for it and the destination is not the program counter. The next-state flags are also brought out so that a downstream stage can forward them. The carry used by the carry-consuming operations comes in on its own pin, normally tied to the C bit of the status word. This block has no stream traffic, so every pin is a plain level signal.

Top module: `alu_dp16`

## Requirements
- R1: The opcode selects the result as follows: 0000 a AND b, 0001 a XOR b, 0010 a−b, 0011 b−a, 0100 a+b, 0101 a+b+cin, 0110 a−b+cin−1, 0111 b−a+cin−1, 1000 a AND b, 1001 a XOR b, 1010 a−b, 1011 a+b, 1100 a OR b, 1101 b, 1110 a AND NOT b, 1111 NOT b.
- R2: `result_we` is low for opcodes 1000 through 1011 and high for every other opcode.
- R3: For opcodes 1101 and 1111 the result and flags do not depend on `op_a`.
- R4: For the bitwise opcodes (0000, 0001, 1000, 1001, 1100, 1101, 1110, 1111), when flags update: N equals result bit 31, Z is 1 exactly when the result is zero, C takes `shift_carry`, and V keeps its stored value.
- R5: For the bitwise opcodes, when `shift_lsl0` is high, C keeps its stored value instead of taking `shift_carry`.
- R6: For the adder opcodes (0010–0111, 1010, 1011), C is the carry out of bit 31, where subtraction is computed as x + NOT y + 1 (or + cin for the carry forms), so C=1 means no borrow. N and Z follow the result as in R4.
- R7: For the adder opcodes, V is 1 exactly when the signed two's-complement result overflows 32 bits.
- R8: The flags update only when `set_flags` is high and `dest_pc` is low. Otherwise `next_flags` equals `flags` and `flags` holds across the edge.
- R9: `flags` is ordered {N,Z,C,V} from bit 3 down to bit 0. It is cleared to 0000 by a synchronous active-high `rst` and loads `next_flags` on each rising clock edge.
- R10: Opcodes 0101, 0110 and 0111 use `carry_in` as the adder's carry-in. The other opcodes ignore it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the status word |
| opcode | input | 4 | Operation select |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand (shifter output) |
| carry_in | input | 1 | Carry for add/subtract-with-carry forms |
| shift_carry | input | 1 | Carry-out of the operand shifter |
| shift_lsl0 | input | 1 | Shift was a left shift by zero |
| set_flags | input | 1 | Instruction requests a flag update |
| dest_pc | input | 1 | Destination register is the program counter |
| result | output | 32 | Operation result |
| result_we | output | 1 | Result should be written to the destination |
| next_flags | output | 4 | Flag values to be loaded at the next edge |
| flags | output | 4 | Registered status word {N,Z,C,V} |

## Verification
The assertions assume that every input is a known level during each clock cycle once reset is released, and that `set_flags` and `dest_pc` are meaningful in the same cycle as the opcode they qualify. They place no constraint on `carry_in` relative to the stored C. The stimulus changes all inputs only on the falling edge and holds them through the next rising edge. It sweeps every opcode against fixed corner operands (zero, all-ones, 0x7FFFFFFF, 0x80000000) with both carry-in values, and then runs random operands. Within the random run, flag updates are sometimes suppressed, and zero-amount shifts are mixed in.

// File: rtl/alu_dp16_pkg.sv
`timescale 1ns/1ps
package alu_dp16_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'b0000, OP_XOR = 4'b0001, OP_SUB = 4'b0010, OP_RSB = 4'b0011,
    OP_ADD = 4'b0100, OP_ADC = 4'b0101, OP_SBC = 4'b0110, OP_RSC = 4'b0111,
    OP_TAN = 4'b1000, OP_TXR = 4'b1001, OP_CPS = 4'b1010, OP_CPA = 4'b1011,
    OP_ORR = 4'b1100, OP_MOV = 4'b1101, OP_BCL = 4'b1110, OP_MVN = 4'b1111
  } alu_op_e;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;
  localparam int FLAG_W = 4;
endpackage

// File: rtl/alu_adder.sv
`timescale 1ns/1ps
module alu_adder
  import alu_dp16_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf,
  output logic             is_arith
);
  localparam int MSB = WIDTH - 1;

  logic             swap, invert;
  logic             c0;
  logic [WIDTH-1:0] x, y_raw, y;
  logic [WIDTH:0]   wide;

  always_comb begin
    swap   = (op == OP_RSB) || (op == OP_RSC);
    invert = (op == OP_SUB) || (op == OP_RSB) || (op == OP_SBC) ||
             (op == OP_RSC) || (op == OP_CPS);
    unique case (op)
      OP_SUB, OP_RSB, OP_CPS: c0 = 1'b1;
      OP_ADC, OP_SBC, OP_RSC: c0 = cin;
      default:                c0 = 1'b0;
    endcase
    is_arith = (op == OP_SUB) || (op == OP_RSB) || (op == OP_ADD) ||
               (op == OP_ADC) || (op == OP_SBC) || (op == OP_RSC) ||
               (op == OP_CPS) || (op == OP_CPA);
  end

  assign x     = swap ? b : a;
  assign y_raw = swap ? a : b;
  assign y     = invert ? ~y_raw : y_raw;
  assign wide  = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, c0};
  assign sum   = wide[WIDTH-1:0];
  assign cout  = wide[WIDTH];
  assign ovf   = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
endmodule

// File: rtl/alu_logic.sv
`timescale 1ns/1ps
module alu_logic
  import alu_dp16_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] res
);
  always_comb begin
    unique case (op)
      OP_AND, OP_TAN: res = a & b;
      OP_XOR, OP_TXR: res = a ^ b;
      OP_ORR:         res = a | b;
      OP_MOV:         res = b;
      OP_BCL:         res = a & ~b;
      OP_MVN:         res = ~b;
      default:        res = '0;
    endcase
  end
endmodule

// File: rtl/alu_flag_reg.sv
`timescale 1ns/1ps
module alu_flag_reg
  import alu_dp16_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic              logic_op,
  input  logic              lsl0,
  input  logic [WIDTH-1:0]  res,
  input  logic              add_cout,
  input  logic              add_ovf,
  input  logic              shc,
  output logic [FLAG_W-1:0] flags_d,
  output logic [FLAG_W-1:0] flags_q
);
  logic [FLAG_W-1:0] computed;

  always_comb begin
    computed[FLAG_N] = res[WIDTH-1];
    computed[FLAG_Z] = (res == '0);
    if (logic_op) begin
      computed[FLAG_C] = lsl0 ? flags_q[FLAG_C] : shc;
      computed[FLAG_V] = flags_q[FLAG_V];
    end else begin
      computed[FLAG_C] = add_cout;
      computed[FLAG_V] = add_ovf;
    end
    flags_d = upd ? computed : flags_q;
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_d;
  end

  // R8: without an update request the status word is frozen
  p_flags_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(flags_q));

  // R4: bitwise operations leave overflow untouched
  p_logic_v_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (upd && logic_op) |=> (flags_q[FLAG_V] == $past(flags_q[FLAG_V])));

  // R9: after a reset cycle the status word is clear
  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (flags_q == '0));
endmodule

// File: rtl/alu_dp16.sv
`timescale 1ns/1ps
module alu_dp16
  import alu_dp16_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        opcode,
  input  logic [WIDTH-1:0]  op_a,
  input  logic [WIDTH-1:0]  op_b,
  input  logic              carry_in,
  input  logic              shift_carry,
  input  logic              shift_lsl0,
  input  logic              set_flags,
  input  logic              dest_pc,
  output logic [WIDTH-1:0]  result,
  output logic              result_we,
  output logic [FLAG_W-1:0] next_flags,
  output logic [FLAG_W-1:0] flags
);
  alu_op_e          op;
  logic [WIDTH-1:0] add_sum, log_res;
  logic             add_cout, add_ovf, is_arith, upd;

  assign op = alu_op_e'(opcode);

  alu_adder #(.WIDTH(WIDTH)) u_adder (
    .op(op), .a(op_a), .b(op_b), .cin(carry_in),
    .sum(add_sum), .cout(add_cout), .ovf(add_ovf), .is_arith(is_arith)
  );

  alu_logic #(.WIDTH(WIDTH)) u_logic (
    .op(op), .a(op_a), .b(op_b), .res(log_res)
  );

  assign result    = is_arith ? add_sum : log_res;
  assign result_we = (opcode[3:2] != 2'b10);
  assign upd       = set_flags && !dest_pc;

  alu_flag_reg #(.WIDTH(WIDTH)) u_flags (
    .clk(clk), .rst(rst), .upd(upd), .logic_op(!is_arith),
    .lsl0(shift_lsl0), .res(result), .add_cout(add_cout),
    .add_ovf(add_ovf), .shc(shift_carry),
    .flags_d(next_flags), .flags_q(flags)
  );

  // R2: compare and test opcodes never request a write
  p_test_nowrite_r2: assert property (@(posedge clk) disable iff (rst)
    (opcode[3:2] == 2'b10) |-> !result_we);

  // R5: a zero-amount left shift preserves carry on bitwise operations
  p_lsl0_keep_c_r5: assert property (@(posedge clk) disable iff (rst)
    (upd && !is_arith && shift_lsl0) |=> (flags[FLAG_C] == $past(flags[FLAG_C])));

  // R4: stored Z reflects the result that was flagged
  p_zero_flag_r4: assert property (@(posedge clk) disable iff (rst)
    upd |=> (flags[FLAG_Z] == ($past(result) == '0)));
endmodule

// File: tb/alu_dp16_bench.sv
`timescale 1ns/1ps
module alu_dp16_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  opcode = '0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        carry_in = 1'b0, shift_carry = 1'b0, shift_lsl0 = 1'b0;
  logic        set_flags = 1'b0, dest_pc = 1'b0;
  logic [31:0] result;
  logic        result_we;
  logic [3:0]  next_flags, flags;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [3:0] m_flags = 4'b0000;

  always #5 clk = ~clk;

  alu_dp16 u_alu_dp16 (
    .clk(clk), .rst(rst), .opcode(opcode), .op_a(op_a), .op_b(op_b),
    .carry_in(carry_in), .shift_carry(shift_carry), .shift_lsl0(shift_lsl0),
    .set_flags(set_flags), .dest_pc(dest_pc), .result(result),
    .result_we(result_we), .next_flags(next_flags), .flags(flags)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (op=%b a=%h b=%h)", tag, act, exp, opcode, op_a, op_b);
    end
  endtask

  task automatic model(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic ci, input logic sc, input logic l0,
                       input logic sf, input logic pc,
                       output logic [31:0] r, output logic we, output logic [3:0] nf,
                       output bit arith);
    longint ua = longint'(a);
    longint ub = longint'(b);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint u = 0, s = 0;
    logic c, v;
    arith = 1'b1;
    case (o)
      4'd2, 4'd10: begin u = ua - ub;          s = sa - sb; end
      4'd3:        begin u = ub - ua;          s = sb - sa; end
      4'd4, 4'd11: begin u = ua + ub;          s = sa + sb; end
      4'd5:        begin u = ua + ub + ci;     s = sa + sb + ci; end
      4'd6:        begin u = ua - ub - 1 + ci; s = sa - sb - 1 + ci; end
      4'd7:        begin u = ub - ua - 1 + ci; s = sb - sa - 1 + ci; end
      default:     arith = 1'b0;
    endcase
    if (arith) begin
      r = u[31:0];
      if (o == 4'd4 || o == 4'd5 || o == 4'd11) c = (u >= 64'sd4294967296);
      else c = (u >= 0);
      v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    end else begin
      case (o)
        4'd0, 4'd8: r = a & b;
        4'd1, 4'd9: r = a ^ b;
        4'd12:      r = a | b;
        4'd13:      r = b;
        4'd14:      r = a & ~b;
        default:    r = ~b;
      endcase
      c = l0 ? m_flags[1] : sc;
      v = m_flags[0];
    end
    we = !(o >= 4'd8 && o <= 4'd11);
    if (sf && !pc) nf = {r[31], (r == 32'd0), c, v};
    else           nf = m_flags;
  endtask

  task automatic run_op(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                        input logic ci, input logic sc, input logic l0,
                        input logic sf, input logic pc);
    logic [31:0] er;
    logic ew;
    logic [3:0] enf;
    bit ar;
    string rtag, ftag;
    @(negedge clk);
    check("R9 registered flags", {28'd0, flags}, {28'd0, m_flags});
    opcode = o; op_a = a; op_b = b; carry_in = ci; shift_carry = sc;
    shift_lsl0 = l0; set_flags = sf; dest_pc = pc;
    model(o, a, b, ci, sc, l0, sf, pc, er, ew, enf, ar);
    if (o == 4'd13 || o == 4'd15) rtag = "R3 result";
    else if (o >= 4'd5 && o <= 4'd7) rtag = "R10 result";
    else rtag = "R1 result";
    if (!(sf && !pc)) ftag = "R8 flags";
    else if (!ar && l0) ftag = "R5 flags";
    else if (!ar) ftag = "R4 flags";
    else ftag = "R6 R7 flags";
    #4;
    check(rtag, result, er);
    check("R2 write enable", {31'd0, result_we}, {31'd0, ew});
    check(ftag, {28'd0, next_flags}, {28'd0, enf});
    @(posedge clk);
    m_flags = enf;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [31:0] corners [6];
    corners[0] = 32'h0000_0000; corners[1] = 32'hFFFF_FFFF;
    corners[2] = 32'h7FFF_FFFF; corners[3] = 32'h8000_0000;
    corners[4] = 32'h0000_0001; corners[5] = 32'h1234_5678;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R9 reset value", {28'd0, flags}, 32'd0);

    // R1 R6 R7 R10: every opcode against corner operands and both carry-in values
    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j += 1)
          for (int c = 0; c < 2; c++)
            if (j == i || j == (i + 1) % 6 || j == 3 - (i % 4))
              run_op(4'(o), corners[i], corners[j], 1'(c), 1'(i[0]), 1'b0, 1'b1, 1'b0);

    // R5: establish C=1, then zero-amount shift with shifter carry 0 keeps it
    run_op(4'd4, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    run_op(4'd0, 32'hF0F0_0000, 32'h0F0F_0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    run_op(4'd13, 32'h0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    // R3: move forms with differing first operand
    run_op(4'd13, 32'hDEAD_BEEF, 32'h8000_0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    run_op(4'd13, 32'h0000_0000, 32'h8000_0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    run_op(4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    run_op(4'd15, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    // R8: no update when flags disabled or destination is the program counter
    run_op(4'd10, 32'h0, 32'h1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    run_op(4'd10, 32'h5, 32'h5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);

    for (int k = 0; k < 1500; k++) begin
      logic [31:0] ra = $urandom;
      logic [31:0] rb = $urandom;
      if (k % 7 == 0) rb = ra;
      if (k % 11 == 0) ra = 32'h7FFF_FFFF;
      run_op(4'($urandom_range(0, 15)), ra, rb, 1'($urandom), 1'($urandom),
             1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 4) != 0),
             1'($urandom_range(0, 5) == 0));
    end

    @(negedge clk);
    check("R9 registered flags", {28'd0, flags}, {28'd0, m_flags});
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule